// File: doc/BRIEF.md
# Latched Interrupt Aggregator with Set/Clear Masks

This block funnels 32 interrupt sources into a single parent interrupt line. Each source owns one bit in every register. Each source passes through a two-stage synchronizer. The synchronized value either sets a sticky status bit on a rising edge (latched variant) or is shown directly as a live level (level variant). Software sees the block through a single-cycle 32-bit register strobe addressed by byte offset. It acknowledges latched events by writing ones. It changes the mask only through two write-one ports: one port disables sources and the other enables them. A mask bit of 1 means the source is disabled.

The parameter `LEVEL_MODE` selects the variant. The level variant has no acknowledge register, so its mask registers sit at lower offsets. Reads return data combinationally from the address presented in the same cycle.

Top module: `irq_fanin_latch`

## Requirements
- R1: After reset every mask bit reads 1, every status bit reads 0, and `irq_o` is low.
- R2: A write to the mask-disable port sets each mask bit where the written word holds a 1. Mask bits where the word holds a 0 keep their value. The port sits at offset 0x10 in latched mode and 0x08 in level mode.
- R3: A write to the mask-enable port clears each mask bit where the written word holds a 1. Mask bits where the word holds a 0 keep their value. The port sits at offset 0x14 in latched mode and 0x0C in level mode.
- R4: Reading the mask view returns the current mask, with 1 meaning the source is masked. The view sits at offset 0x0C in latched mode and 0x04 in level mode.
- R5: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R6: In latched mode a rising edge on a source sets its status bit, readable at offset 0x00, no later than three clock edges after the edge. The bit holds until a 1 is written to that bit position at offset 0x08. Zero bits in that write leave status unchanged.
- R7: In latched mode, if a new rising edge and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R8: In level mode, offset 0x00 shows the synchronized live level of each source. Writes to offset 0x00 have no effect.
- R9: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing. Offset 0x04 is unmapped in latched mode, and offsets 0x10 and above are unmapped in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt sources, one per bit |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Parent interrupt line |

## Verification
The bench builds two copies side by side: one with `LEVEL_MODE=0` and one with `LEVEL_MODE=1`, both with the default 5-bit address. Both register maps and the unmapped holes of each map are therefore exercised in one run. Because the width is only 32 sources, every bit can be swept one by one, so each bit position sees an edge or level, an unmask, a partial acknowledge, a full acknowledge and a remask. The two-stage synchronizer makes a deliberate collision easy to time: an edge can be aimed to land in the same cycle as an acknowledge.

// File: rtl/irq_fanin_latch.sv
module irq_fanin_latch #(
  parameter bit LEVEL_MODE = 1'b0,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(LEVEL_MODE ? 4  : 12);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(LEVEL_MODE ? 8  : 16);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(LEVEL_MODE ? 12 : 20);

  logic [31:0] sync1, sync2, mask_q, stat_v;

  wire hit_set = bus_wr && (bus_addr == A_SET);
  wire hit_clr = bus_wr && (bus_addr == A_CLR);
  wire hit_ack = !LEVEL_MODE && bus_wr && (bus_addr == A_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else
      mask_q <= (mask_q | (hit_set ? bus_wdata : 32'h0)) &
                ~(hit_clr ? bus_wdata : 32'h0);
  end

  generate
    if (LEVEL_MODE) begin : g_level
      assign stat_v = sync2;
    end else begin : g_latch
      logic [31:0] prev_q, stat_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= '0;
          stat_q <= '0;
        end else begin
          prev_q <= sync2;
          stat_q <= (stat_q & ~(hit_ack ? bus_wdata : 32'h0)) | (sync2 & ~prev_q);
        end
      end
      assign stat_v = stat_q;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)     bus_rdata = stat_v;
    else if (bus_addr == A_MSK) bus_rdata = mask_q;
  end

  assign irq_o = |(stat_v & ~mask_q);
endmodule

module irq_fanin_latch_chk #(
  parameter bit LEVEL_MODE = 1'b0,
  parameter int ADDR_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_v,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(LEVEL_MODE ? 8  : 16);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(LEVEL_MODE ? 12 : 20);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((mask_q & $past(bus_wdata)) == 32'h0));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(mask_q));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'hFFFF_FFFF || stat_v == 32'h0) |-> !irq_o);

  generate
    if (!LEVEL_MODE) begin : g_latch_chk
      // R6
      stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_ACK) |=> ((stat_v & $past(stat_v)) == $past(stat_v)));
    end
  endgenerate
endmodule

bind irq_fanin_latch irq_fanin_latch_chk #(.LEVEL_MODE(LEVEL_MODE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .stat_v(stat_v), .irq_o(irq_o)
);

// File: tb/sim_irq_fanin_latch.sv
module sim_irq_fanin_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_fanin_latch #(.LEVEL_MODE(1'b0), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr0), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq_o(irq0));
  irq_fanin_latch #(.LEVEL_MODE(1'b1), .ADDR_W(5)) u1 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr1), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq_o(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit lvl, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (lvl) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit lvl, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = lvl ? rdata1 : rdata0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    // R1
    rd(0, 5'h0C, d); chk("R1 latched mask", d, 32'hFFFF_FFFF);
    rd(0, 5'h00, d); chk("R1 latched status", d, 32'h0);
    rd(1, 5'h04, d); chk("R1 level mask", d, 32'hFFFF_FFFF);
    chk("R1 irq", {30'h0, irq1, irq0}, 32'h0);

    // latched sweep: R2 R3 R4 R5 R6
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      @(negedge clk); src = b;
      idle(4);
      src = '0;
      idle(4);
      rd(0, 5'h00, d); chk("R6 edge latched", d, b);
      #1 chk("R5 masked no irq", {31'h0, irq0}, 32'h0);
      wr(0, 5'h14, b);
      rd(0, 5'h0C, d); chk("R3 R4 unmask one bit", d, ~b);
      #1 chk("R5 irq when unmasked", {31'h0, irq0}, 32'h1);
      wr(0, 5'h08, ~b);
      rd(0, 5'h00, d); chk("R6 zero ack bits keep status", d, b);
      wr(0, 5'h08, b);
      rd(0, 5'h00, d); chk("R6 ack clears", d, 32'h0);
      #1 chk("R5 irq drops after ack", {31'h0, irq0}, 32'h0);
      wr(0, 5'h10, b);
      rd(0, 5'h0C, d); chk("R2 remask", d, 32'hFFFF_FFFF);
    end

    // R2 R3 partial words
    wr(0, 5'h14, 32'h00FF_00F0);
    wr(0, 5'h14, 32'h0);
    rd(0, 5'h0C, d); chk("R3 zero write keeps mask", d, 32'hFF00_FF0F);
    wr(0, 5'h10, 32'h0000_0030);
    wr(0, 5'h10, 32'h0);
    rd(0, 5'h0C, d); chk("R2 set subset", d, 32'hFF00_FF3F);

    // R7 edge and ack in same cycle on bit 5
    @(negedge clk); src = 32'h20;
    idle(4); src = '0; idle(4);
    rd(0, 5'h00, d); chk("R7 prep status", d, 32'h20);
    @(negedge clk); src = 32'h20;
    @(negedge clk);
    wr(0, 5'h08, 32'h20);
    rd(0, 5'h00, d); chk("R7 set wins over ack", d, 32'h20);
    src = '0; idle(4);
    wr(0, 5'h08, 32'hFFFF_FFFF);
    rd(0, 5'h00, d); chk("R6 full ack", d, 32'h0);

    // R9 latched unmapped
    wr(0, 5'h04, 32'hFFFF_FFFF);
    wr(0, 5'h18, 32'hFFFF_FFFF);
    wr(0, 5'h11, 32'hFFFF_FFFF);
    rd(0, 5'h0C, d); chk("R9 latched unmapped write", d, 32'hFF00_FF3F);
    rd(0, 5'h04, d); chk("R9 latched read 0x04", d, 32'h0);
    rd(0, 5'h18, d); chk("R9 latched read 0x18", d, 32'h0);

    // level sweep: R8 R5 R2 R3
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      @(negedge clk); src = b;
      idle(3);
      rd(1, 5'h00, d); chk("R8 live level", d, b);
      #1 chk("R5 level masked", {31'h0, irq1}, 32'h0);
      wr(1, 5'h0C, b);
      rd(1, 5'h04, d); chk("R3 R4 level unmask", d, ~b);
      #1 chk("R5 level irq", {31'h0, irq1}, 32'h1);
      @(negedge clk); src = '0;
      idle(3);
      rd(1, 5'h00, d); chk("R8 level follows low", d, 32'h0);
      #1 chk("R5 level irq drops", {31'h0, irq1}, 32'h0);
      wr(1, 5'h08, b);
      rd(1, 5'h04, d); chk("R2 level remask", d, 32'hFFFF_FFFF);
    end

    // R8 status write ignored, R9 level unmapped
    @(negedge clk); src = 32'hA5A5_0F0F;
    idle(3);
    wr(1, 5'h00, 32'h0);
    wr(1, 5'h00, 32'hFFFF_FFFF);
    rd(1, 5'h00, d); chk("R8 status write ignored", d, 32'hA5A5_0F0F);
    rd(1, 5'h04, d); chk("R8 status write leaves mask", d, 32'hFFFF_FFFF);
    wr(1, 5'h0C, 32'hFFFF_FFFF);
    wr(1, 5'h10, 32'hFFFF_FFFF);
    wr(1, 5'h14, 32'hFFFF_FFFF);
    rd(1, 5'h04, d); chk("R9 level unmapped write", d, 32'h0);
    rd(1, 5'h10, d); chk("R9 level read 0x10", d, 32'h0);
    rd(1, 5'h14, d); chk("R9 level read 0x14", d, 32'h0);
    #1 chk("R5 level irq unmasked pattern", {31'h0, irq1}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule